// File: doc/BRIEF.md
# Channel-Select Register Controller for a Serial Two-Wire Bus Switch

This block is the logic behind a four-way downstream bus switch. It is an I2C target that holds one control byte. The low half of that byte picks which of four downstream channels are connected. The block samples the upstream SCL and SDA lines with a fast system clock. It removes short glitches from both lines, finds START and STOP conditions and bit edges, and decodes its 7-bit address. It then stores written bytes or returns the control byte on a read.

A write does not change the channel enables at once. The new selection is held in the control byte and only reaches the `chan_en` outputs when the next STOP is seen. This way a channel is never connected in the middle of a transfer. A read returns the live interrupt state of the four channels in the high nibble, on top of the stored selection in the low nibble. The enables are plain logic outputs. SDA is driven through an open-drain pull-low enable.

Top module: `chsel_ctrl`

## Requirements
- R1: While `rst` is high, or after it, `chan_en` is 0, `sda_pull` is 0, and the control byte reads back as 0 in its low nibble.
- R2: The target address is the 7 bits 1,1,1,0,0,`addr_pins[1]`,`addr_pins[0]`, sent MSB first and followed by the direction bit (1 = read, 0 = write). On a match, the target pulls SDA low for the ninth clock.
- R3: Any other address gets no acknowledge. The rest of that transfer, up to the next START or STOP, changes neither the control byte nor `chan_en`.
- R4: Each acknowledged write data byte is stored whole, and the target acknowledges it. `chan_en` keeps its old value until a STOP, then takes bits 3..0 of the stored byte.
- R5: When several data bytes are written before one STOP, the last byte is the one kept.
- R6: A read returns one byte, MSB first. Bit 4+n is 1 when `irq_req[n]` is high, and bits 3..0 are the stored selection. The byte is shifted out again while the master keeps acknowledging.
- R7: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks is ignored. It causes no extra bit, START or STOP.
- R8: A repeated START restarts address decoding without applying the pending selection to `chan_en`.
- R9: `sda_pull` changes only while the filtered SCL is low. During the master's acknowledge slot of a read, SDA is released.
- R10: Any mix of channel bits is allowed, including all four at once. Bit n of `chan_en` enables channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| addr_pins | input | 2 | Strapped low address bits |
| scl_in | input | 1 | Upstream serial clock as seen on the wire |
| sda_in | input | 1 | Upstream serial data as seen on the wire |
| irq_req | input | 4 | Active-high interrupt pending, one per channel |
| sda_pull | output | 1 | 1 = pull the upstream SDA line low |
| chan_en | output | 4 | Channel enables, bit n for channel n |

## Verification
The bench goes after the staging rule first. A write is checked before its STOP and after it, and a repeated START into a read is checked too. A design that applied the selection early would move `chan_en` in mid-transfer, and one that applied it on a repeated START would show the new value before the STOP. A wrong-address transfer followed by data must leave both the register and the enables alone; a faulty address compare would acknowledge it or store the byte. Sub-threshold pulses are placed on SCL during a low phase and on SDA during a high phase. A weak filter would add a bit or see a false START and so corrupt the stored byte. The read test drives distinct interrupt patterns and a master NACK. It catches nibble swaps, reversed channel order, and a target that keeps holding SDA during the master's acknowledge.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int CH_N   = 4;
  localparam int BYTE_W = 2 * CH_N;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK,
    ST_SKIP
  } slv_state_t;
endpackage

// File: rtl/chsel_line_filter.sv
module chsel_line_filter #(
  parameter int   FILT_LEN = 6,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic             sy1, sy2;
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sy1     <= RST_VAL;
      sy2     <= RST_VAL;
      dout    <= RST_VAL;
      run_cnt <= '0;
    end else begin
      sy1 <= din;
      sy2 <= sy1;
      if (sy2 == dout) begin
        run_cnt <= '0;
      end else if (run_cnt == CNT_W'(FILT_LEN - 1)) begin
        dout    <= sy2;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/chsel_bus_events.sv
module chsel_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign ev_start = scl_f & scl_q & sda_q & ~sda_f;
  assign ev_stop  = scl_f & scl_q & ~sda_q & sda_f;
  assign ev_rise  = scl_f & ~scl_q;
  assign ev_fall  = ~scl_f & scl_q;
endmodule

// File: rtl/chsel_slave_fsm.sv
module chsel_slave_fsm
  import chsel_pkg::*;
#(
  parameter logic [4:0] ADDR_FIX = 5'b11100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      addr_pins,
  input  logic            sda_f,
  input  logic            ev_start,
  input  logic            ev_stop,
  input  logic            ev_rise,
  input  logic            ev_fall,
  input  logic [CH_N-1:0] irq_live,
  output logic            sda_pull,
  output logic [CH_N-1:0] chan_en
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  slv_state_t        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txreg;
  logic [BYTE_W-1:0] ctrl;
  logic              rw_bit;
  logic              mst_nack;
  logic [BYTE_W-1:0] rd_byte;
  logic              byte_end;
  logic              addr_hit;

  assign rd_byte  = {irq_live, ctrl[CH_N-1:0]};
  assign byte_end = ev_fall && (bit_cnt == CNT_W'(BYTE_W));
  assign addr_hit = (shreg[BYTE_W-1:1] == {ADDR_FIX, addr_pins});

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      txreg    <= '0;
      ctrl     <= '0;
      rw_bit   <= 1'b0;
      mst_nack <= 1'b0;
      sda_pull <= 1'b0;
      chan_en  <= '0;
    end else if (ev_stop) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
      chan_en  <= ctrl[CH_N-1:0];
    end else if (ev_start) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (ev_rise) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_f};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_end) begin
            if (addr_hit) begin
              rw_bit   <= shreg[0];
              sda_pull <= 1'b1;
              state    <= ST_AACK;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (ev_fall) begin
            bit_cnt <= '0;
            if (rw_bit) begin
              txreg    <= rd_byte;
              sda_pull <= ~rd_byte[BYTE_W-1];
              state    <= ST_RD;
            end else begin
              sda_pull <= 1'b0;
              state    <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (ev_rise) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_f};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_end) begin
            ctrl     <= shreg;
            sda_pull <= 1'b1;
            state    <= ST_WACK;
          end
        end
        ST_WACK: begin
          if (ev_fall) begin
            sda_pull <= 1'b0;
            bit_cnt  <= '0;
            state    <= ST_WR;
          end
        end
        ST_RD: begin
          if (ev_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_end) begin
            sda_pull <= 1'b0;
            state    <= ST_RACK;
          end else if (ev_fall) begin
            txreg    <= {txreg[BYTE_W-2:0], 1'b0};
            sda_pull <= ~txreg[BYTE_W-2];
          end
        end
        ST_RACK: begin
          if (ev_rise) begin
            mst_nack <= sda_f;
          end else if (ev_fall) begin
            if (mst_nack) begin
              state <= ST_SKIP;
            end else begin
              bit_cnt  <= '0;
              txreg    <= rd_byte;
              sda_pull <= ~rd_byte[BYTE_W-1];
              state    <= ST_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/chsel_ctrl.sv
module chsel_ctrl
  import chsel_pkg::*;
#(
  parameter int         FILT_LEN = 6,
  parameter logic [4:0] ADDR_FIX = 5'b11100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      addr_pins,
  input  logic            scl_in,
  input  logic            sda_in,
  input  logic [CH_N-1:0] irq_req,
  output logic            sda_pull,
  output logic [CH_N-1:0] chan_en
);
  logic            scl_flt, sda_flt;
  logic            ev_start, ev_stop, ev_rise, ev_fall;
  logic [CH_N-1:0] irq_flt;

  chsel_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_scl_flt (
    .clk(clk), .rst(rst), .din(scl_in), .dout(scl_flt)
  );

  chsel_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_sda_flt (
    .clk(clk), .rst(rst), .din(sda_in), .dout(sda_flt)
  );

  for (genvar g = 0; g < CH_N; g++) begin : g_irq
    chsel_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b0)) u_irq_flt (
      .clk(clk), .rst(rst), .din(irq_req[g]), .dout(irq_flt[g])
    );
  end

  chsel_bus_events u_events (
    .clk(clk), .rst(rst), .scl_f(scl_flt), .sda_f(sda_flt),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  chsel_slave_fsm #(.ADDR_FIX(ADDR_FIX)) u_fsm (
    .clk(clk), .rst(rst), .addr_pins(addr_pins), .sda_f(sda_flt),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .irq_live(irq_flt), .sda_pull(sda_pull), .chan_en(chan_en)
  );
endmodule

// File: rtl/chsel_ctrl_chk.sv
module chsel_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_f,
  input logic       ev_stop,
  input logic       sda_pull,
  input logic [3:0] chan_en
);
  // R1: outputs are cleared on leaving reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (chan_en == 4'd0 && !sda_pull));

  // R4: the enables move only right after a STOP
  a_r4_apply_on_stop: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_en) |-> $past(ev_stop));

  // R9: SDA is never newly pulled while SCL is high
  a_r9_pull_rise_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !$past(scl_f));

  // R9: SDA drive holds steady through an SCL high phase
  a_r9_pull_stable_high: assert property (@(posedge clk) disable iff (rst)
    (scl_f && $past(scl_f)) |-> $stable(sda_pull));
endmodule

bind chsel_ctrl chsel_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .scl_f(scl_flt), .ev_stop(ev_stop),
  .sda_pull(sda_pull), .chan_en(chan_en)
);

// File: tb/tb_chsel_ctrl.sv
`timescale 1ns/1ps
module tb_chsel_ctrl;
  localparam int Q = 20;
  localparam logic [7:0] WR_ADDR = 8'hE4;
  localparam logic [7:0] RD_ADDR = 8'hE5;
  localparam logic [7:0] BAD_ADDR = 8'hE6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] addr_pins = 2'b10;
  logic       scl_in = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_in;
  logic [3:0] irq_req = 4'd0;
  logic       sda_pull;
  logic [3:0] chan_en;

  int checks = 0;
  int errors = 0;

  assign sda_in = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  chsel_ctrl dut (
    .clk(clk), .rst(rst), .addr_pins(addr_pins), .scl_in(scl_in),
    .sda_in(sda_in), .irq_req(irq_req), .sda_pull(sda_pull), .chan_en(chan_en)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_in = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_in = 1'b0; wt(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wt(Q);
    scl_in = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_in = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl_in = 1'b1; wt(Q);
    sda_m = 1'b1; wt(2 * Q);
  endtask

  // g: 0 none, 1 short SCL pulse in a low phase, 2 short SDA dip in a high phase
  task automatic send_byte(input logic [7:0] b, input int g, output logic ack);
    for (int i = 0; i < 8; i++) begin
      sda_m = b[7-i]; wt(Q);
      if (g == 1 && i == 2) begin
        scl_in = 1'b1; wt(3); scl_in = 1'b0; wt(Q);
      end
      scl_in = 1'b1; wt(Q);
      if (g == 2 && i == 5 && b[7-i]) begin
        sda_m = 1'b0; wt(3); sda_m = 1'b1;
      end
      wt(Q);
      scl_in = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q);
    scl_in = 1'b1; wt(Q);
    ack = sda_in;
    wt(Q);
    scl_in = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d, output logic slot);
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; wt(Q);
      scl_in = 1'b1; wt(Q);
      d[7-i] = sda_in;
      wt(Q);
      scl_in = 1'b0; wt(Q);
    end
    sda_m = mack ? 1'b0 : 1'b1; wt(Q);
    scl_in = 1'b1; wt(Q);
    slot = sda_pull;
    wt(Q);
    scl_in = 1'b0; wt(Q);
  endtask

  task automatic t_reset();
    logic ack; logic [7:0] d; logic slot;
    chk("R1 chan_en after reset", {4'd0, chan_en}, 8'h00);
    chk("R1 sda_pull after reset", {7'd0, sda_pull}, 8'h00);
    bus_start();
    send_byte(RD_ADDR, 0, ack);
    chk("R2 read address ack", {7'd0, ack}, 8'h00);
    recv_byte(1'b0, d, slot);
    bus_stop();
    chk("R1 register reads zero", d, 8'h00);
  endtask

  task automatic t_write_stop();
    logic ack;
    bus_start();
    send_byte(WR_ADDR, 0, ack);
    chk("R2 write address ack", {7'd0, ack}, 8'h00);
    send_byte(8'h05, 0, ack);
    chk("R4 data ack", {7'd0, ack}, 8'h00);
    chk("R4 enables held before STOP", {4'd0, chan_en}, 8'h00);
    bus_stop();
    chk("R4 enables after STOP", {4'd0, chan_en}, 8'h05);
  endtask

  task automatic t_multi();
    logic ack;
    bus_start();
    send_byte(WR_ADDR, 0, ack);
    send_byte(8'h03, 0, ack);
    send_byte(8'h0A, 0, ack);
    send_byte(8'h0F, 0, ack);
    chk("R5 last data ack", {7'd0, ack}, 8'h00);
    chk("R4 enables unchanged mid-burst", {4'd0, chan_en}, 8'h05);
    bus_stop();
    chk("R5 R10 last byte, all four channels", {4'd0, chan_en}, 8'h0F);
  endtask

  task automatic t_mismatch();
    logic ack; logic [7:0] d; logic slot;
    bus_start();
    send_byte(BAD_ADDR, 0, ack);
    chk("R3 foreign address not acked", {7'd0, ack}, 8'h01);
    send_byte(8'h00, 0, ack);
    chk("R3 foreign data not acked", {7'd0, ack}, 8'h01);
    bus_stop();
    chk("R3 enables untouched", {4'd0, chan_en}, 8'h0F);
    bus_start();
    send_byte(RD_ADDR, 0, ack);
    recv_byte(1'b0, d, slot);
    bus_stop();
    chk("R3 register untouched", d, 8'h0F);
  endtask

  task automatic t_read_irq(input logic [3:0] irq);
    logic ack; logic [7:0] d, d2; logic slot;
    irq_req = irq; wt(Q);
    bus_start();
    send_byte(RD_ADDR, 0, ack);
    recv_byte(1'b1, d, slot);
    chk("R9 released in master ack slot", {7'd0, slot}, 8'h00);
    recv_byte(1'b0, d2, slot);
    chk("R9 released in master nack slot", {7'd0, slot}, 8'h00);
    bus_stop();
    chk("R6 read merges interrupts", d, {irq, chan_en});
    chk("R6 repeated byte on ack", d2, {irq, chan_en});
  endtask

  task automatic t_rstart();
    logic ack; logic [7:0] d; logic slot;
    bus_start();
    send_byte(WR_ADDR, 0, ack);
    send_byte(8'h09, 0, ack);
    bus_rstart();
    send_byte(RD_ADDR, 0, ack);
    chk("R8 address acked after repeated START", {7'd0, ack}, 8'h00);
    recv_byte(1'b0, d, slot);
    chk("R8 read after repeated START", d, {irq_req, 4'h9});
    chk("R8 enables held across repeated START", {4'd0, chan_en}, 8'h0F);
    bus_stop();
    chk("R8 enables after final STOP", {4'd0, chan_en}, 8'h09);
  endtask

  task automatic t_glitch();
    logic ack;
    bus_start();
    send_byte(WR_ADDR, 1, ack);
    chk("R7 ack despite SCL pulse", {7'd0, ack}, 8'h00);
    send_byte(8'h06, 2, ack);
    chk("R7 ack despite SDA dip", {7'd0, ack}, 8'h00);
    bus_stop();
    chk("R7 byte intact after glitches", {4'd0, chan_en}, 8'h06);
  endtask

  task automatic t_reset_mid();
    logic ack;
    bus_start();
    send_byte(WR_ADDR, 0, ack);
    sda_m = 1'b0;
    wt(5);
    rst = 1'b1; scl_in = 1'b1; sda_m = 1'b1;
    wt(4);
    chk("R1 enables cleared by reset", {4'd0, chan_en}, 8'h00);
    chk("R1 SDA released by reset", {7'd0, sda_pull}, 8'h00);
    rst = 1'b0;
    wt(Q);
  endtask

  initial begin
    wt(6);
    rst = 1'b0;
    wt(Q);
    t_reset();
    t_write_stop();
    t_multi();
    t_mismatch();
    t_read_irq(4'b0101);
    t_read_irq(4'b1010);
    irq_req = 4'b0011;
    t_rstart();
    t_glitch();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule